// File: doc/BRIEF.md
# Binary Complement-Mode Adder-Subtractor

This block adds or subtracts two unsigned binary words of parameterised width. It uses only one ripple-carry adder. For subtraction, a row of XOR gates inverts the second operand before it reaches the adder, and the adder's carry-in is chosen by the operation. A carry-in of one gives a plain twos-complement difference. A carry-in of zero gives a ones-complement difference, which is then corrected in one of two ways:

- If the adder produced a carry, that carry is folded back into the low bit (end-around carry).
- If it did not, the adder's sum is inverted.

The ones-complement path therefore delivers a magnitude together with a sign flag. The twos-complement path delivers a wrapped difference whose top bit is the sign.

The block is purely combinational. Each output follows the operands and the operation select within the same cycle, with no register on the path.

Top module: `cmpl_addsub`

## Requirements
- R1: The operation select `op_sel` is decoded as follows: 2'b00 is add, 2'b01 is ones-complement subtract, 2'b10 is twos-complement subtract, and 2'b11 behaves exactly like 2'b00.
- R2: In add mode, `result` equals (A + B) mod 2^W and `carry_out` equals bit W of A + B. `neg` is 0.
- R3: In twos-complement subtract mode, `result` equals (A − B) mod 2^W. `carry_out` is 1 exactly when A ≥ B as unsigned values.
- R4: In twos-complement subtract mode, `neg` equals the most significant bit of `result`, which is the sign of the difference read as a signed value.
- R5: In ones-complement subtract mode, `carry_out` is the raw adder carry, which is 1 exactly when A > B as unsigned values.
- R6: In ones-complement subtract mode with A > B, the end-around carry gives `result` = A − B and `neg` = 0.
- R7: In ones-complement subtract mode with A < B, the inverted sum gives `result` = B − A and `neg` = 1.
- R8: In ones-complement subtract mode with A = B, `result` is 0 and `neg` is 0. This avoids the all-ones negative zero.
- R9: At W = 8, twos-complement subtracting 8'b01110011 from 0 gives 8'b10001101 with `neg` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | DATA_W | First operand (minuend) |
| opnd_b | input | DATA_W | Second operand (subtrahend or addend) |
| op_sel | input | 2 | Operation select, encoded as in R1 |
| result | output | DATA_W | Sum, wrapped difference, or magnitude |
| neg | output | 1 | Sign flag for the subtract modes |
| carry_out | output | 1 | Raw carry out of the shared adder |

## Verification
The bench builds two copies of the block: one with DATA_W = 4 and one with DATA_W = 8.

At DATA_W = 4 every pair of operands can be applied under every op_sel code. This covers, exhaustively:
- equal operands (the negative-zero case);
- borrows that cross every bit position;
- the end-around carry rippling all the way through the incrementer.

The 8-bit copy covers the 01110011 case, all-zero and all-ones operands, and a strided sweep over wider carry chains. In both copies the expected outputs come from integer arithmetic.

// File: rtl/cmpl_addsub_pkg.sv
package cmpl_addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB_1C  = 2'b01,
        OP_SUB_2C  = 2'b10,
        OP_ADD_ALT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        MODE_ADD,
        MODE_SUB_1C,
        MODE_SUB_2C
    } mode_e;

endpackage

// File: rtl/cas_mode_decode.sv
module cas_mode_decode
    import cmpl_addsub_pkg::*;
(
    input  logic [1:0] op_sel,
    output mode_e      mode,
    output logic       invert_b,
    output logic       carry_in
);

    always_comb begin
        unique case (op_e'(op_sel))
            OP_ADD, OP_ADD_ALT: begin
                mode     = MODE_ADD;
                invert_b = 1'b0;
                carry_in = 1'b0;
            end
            OP_SUB_1C: begin
                mode     = MODE_SUB_1C;
                invert_b = 1'b1;
                carry_in = 1'b0;
            end
            OP_SUB_2C: begin
                mode     = MODE_SUB_2C;
                invert_b = 1'b1;
                carry_in = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cas_xor_row.sv
module cas_xor_row #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic              invert,
    output logic [DATA_W-1:0] dout
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[i] ^ invert;
    end

endmodule

// File: rtl/cas_ripple_adder.sv
module cas_ripple_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    logic [DATA_W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < DATA_W; i++) begin : g_fa
        logic half;
        assign half       = x[i] ^ y[i];
        assign sum[i]     = half ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (half & chain[i]);
    end

    assign cout = chain[DATA_W];

endmodule

// File: rtl/cas_result_stage.sv
module cas_result_stage
    import cmpl_addsub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  mode_e             mode,
    input  logic [DATA_W-1:0] sum,
    input  logic              cout,
    output logic [DATA_W-1:0] result,
    output logic              neg
);

    localparam int MSB = DATA_W - 1;

    // End-around carry incrementer: the raw carry re-enters at bit 0.
    logic [DATA_W-1:0] wrap_c;
    logic [DATA_W-1:0] wrapped;

    assign wrap_c[0] = cout;

    for (genvar i = 0; i < DATA_W; i++) begin : g_inc
        assign wrapped[i] = sum[i] ^ wrap_c[i];
        if (i < MSB) begin : g_next
            assign wrap_c[i+1] = sum[i] & wrap_c[i];
        end
    end

    logic sum_all_ones;
    assign sum_all_ones = &sum;

    always_comb begin
        unique case (mode)
            MODE_SUB_1C: begin
                if (cout) begin
                    result = wrapped;
                    neg    = 1'b0;
                end else begin
                    result = ~sum;
                    // An all-ones sum is negative zero: report plain zero.
                    neg    = ~sum_all_ones;
                end
            end
            MODE_SUB_2C: begin
                result = sum;
                neg    = sum[MSB];
            end
            default: begin
                result = sum;
                neg    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cmpl_addsub.sv
module cmpl_addsub
    import cmpl_addsub_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        op_sel,
    output logic [DATA_W-1:0] result,
    output logic              neg,
    output logic              carry_out
);

    mode_e             mode;
    logic              invert_b;
    logic              carry_in;
    logic [DATA_W-1:0] b_cond;
    logic [DATA_W-1:0] raw_sum;

    cas_mode_decode u_decode (
        .op_sel   (op_sel),
        .mode     (mode),
        .invert_b (invert_b),
        .carry_in (carry_in)
    );

    cas_xor_row #(.DATA_W(DATA_W)) u_xor (
        .din    (opnd_b),
        .invert (invert_b),
        .dout   (b_cond)
    );

    cas_ripple_adder #(.DATA_W(DATA_W)) u_adder (
        .x    (opnd_a),
        .y    (b_cond),
        .cin  (carry_in),
        .sum  (raw_sum),
        .cout (carry_out)
    );

    cas_result_stage #(.DATA_W(DATA_W)) u_result (
        .mode   (mode),
        .sum    (raw_sum),
        .cout   (carry_out),
        .result (result),
        .neg    (neg)
    );

endmodule

// File: rtl/cmpl_addsub_chk.sv
module cmpl_addsub_chk #(
    parameter int DATA_W = 8
) (
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] result,
    input logic              neg,
    input logic              carry_out
);

    always_comb begin
        // R2 / R1: both add codes never raise the sign flag
        if (op_sel == 2'b00 || op_sel == 2'b11) begin
            p_add_no_neg_r2: assert (!neg)
                else $error("add mode raised neg");
        end
        // R4: twos-complement sign is the top result bit
        if (op_sel == 2'b10) begin
            p_twos_neg_msb_r4: assert (neg == result[DATA_W-1])
                else $error("twos neg differs from result msb");
        end
        // R6: a ones-complement carry means a positive outcome
        if (op_sel == 2'b01 && carry_out) begin
            p_ones_carry_pos_r6: assert (!neg)
                else $error("ones carry with neg set");
        end
        // R7: negative ones-complement outcome has no carry and nonzero magnitude
        if (op_sel == 2'b01 && neg) begin
            p_ones_neg_nocarry_r7: assert (!carry_out && result != '0)
                else $error("ones negative with carry or zero magnitude");
        end
        // R8: equal operands give plain zero
        if (op_sel == 2'b01 && opnd_a == opnd_b) begin
            p_ones_equal_zero_r8: assert (result == '0 && !neg)
                else $error("ones equal operands not zero");
        end
    end

endmodule

bind cmpl_addsub cmpl_addsub_chk #(.DATA_W(DATA_W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sel    (op_sel),
    .result    (result),
    .neg       (neg),
    .carry_out (carry_out)
);

// File: tb/cmpl_addsub_bench.sv
`timescale 1ns/1ps
module cmpl_addsub_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [3:0] a4, b4;
    logic [7:0] a8, b8;
    logic [1:0] op4, op8;
    logic [3:0] r4;
    logic [7:0] r8;
    logic n4, c4, n8, c8;

    cmpl_addsub #(.DATA_W(4)) u_cmpl_addsub (
        .opnd_a(a4), .opnd_b(b4), .op_sel(op4),
        .result(r4), .neg(n4), .carry_out(c4)
    );

    cmpl_addsub #(.DATA_W(8)) u_cmpl_addsub_w8 (
        .opnd_a(a8), .opnd_b(b8), .op_sel(op8),
        .result(r8), .neg(n8), .carry_out(c8)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Reference model from the requirements.
    task automatic model(input int a, input int b, input int op, input int w,
                         output int res, output int ng, output int cy, output string tag);
        int m;
        m = 1 << w;
        if (op == 1) begin
            cy = (a > b) ? 1 : 0;
            if (a > b)       begin res = a - b; ng = 0; tag = "R6"; end
            else if (a < b)  begin res = b - a; ng = 1; tag = "R7"; end
            else             begin res = 0;     ng = 0; tag = "R8"; end
        end else if (op == 2) begin
            res = (a - b + m) % m;
            cy  = (a >= b) ? 1 : 0;
            ng  = (res >= m / 2) ? 1 : 0;
            tag = "R3";
        end else begin
            res = (a + b) % m;
            cy  = (a + b >= m) ? 1 : 0;
            ng  = 0;
            tag = (op == 3) ? "R1" : "R2";
        end
    endtask

    task automatic run4(input int a, input int b, input int op);
        int er, en, ec;
        string t;
        @(negedge clk);
        a4 = 4'(a); b4 = 4'(b); op4 = 2'(op);
        @(posedge clk); #1;
        model(a, b, op, 4, er, en, ec, t);
        check({t, " result w4"}, int'(r4), er);
        check((op == 2) ? "R4 neg w4" : {t, " neg w4"}, int'(n4), en);
        check((op == 1) ? "R5 carry w4" : {t, " carry w4"}, int'(c4), ec);
    endtask

    task automatic run8(input int a, input int b, input int op);
        int er, en, ec;
        string t;
        @(negedge clk);
        a8 = 8'(a); b8 = 8'(b); op8 = 2'(op);
        @(posedge clk); #1;
        model(a, b, op, 8, er, en, ec, t);
        check({t, " result w8"}, int'(r8), er);
        check((op == 2) ? "R4 neg w8" : {t, " neg w8"}, int'(n8), en);
        check((op == 1) ? "R5 carry w8" : {t, " carry w8"}, int'(c8), ec);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int corners[7];
        corners = '{0, 1, 127, 128, 254, 255, 115};
        a4 = '0; b4 = '0; op4 = '0;
        a8 = '0; b8 = '0; op8 = '0;
        repeat (3) @(posedge clk);
        #1;
        // Idle state with zero operands during reset.
        check("R2 idle result", int'(r4), 0);
        check("R2 idle neg", int'(n4), 0);
        check("R2 idle carry", int'(c4), 0);
        rst_n = 1'b1;

        // R9: twos complement of 01110011 at 8 bits.
        @(negedge clk);
        a8 = 8'h00; b8 = 8'b01110011; op8 = 2'b10;
        @(posedge clk); #1;
        check("R9 result", int'(r8), 8'b10001101);
        check("R9 neg", int'(n8), 1);

        // Exhaustive at 4 bits over all op codes (R1..R8).
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(a, b, op);

        // 8-bit corners and strided sweep.
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    run8(corners[i], corners[j], op);
            for (int a = 0; a < 256; a += 5)
                for (int b = 0; b < 256; b += 7)
                    run8(a, b, op);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule